// File: doc/BRIEF.md
# Programmable Level-Priority Interrupt Controller

This block gathers up to 63 interrupt request lines and reduces them to one 3-bit interrupt level for a processor core. Each request is first qualified by its mask bit. The surviving requests are then ranked by two coordinates: a level (1 to 7) and a priority inside that level. The core sees the highest level in use. When the core acknowledges a level, the block answers one cycle later with a vector number for the best source at that level.

Sources 1 to 7 are wired sources with no settings: source n always sits at level n. Inside its level it ranks halfway between programmable priorities 4 and 3. Each of sources 8 to 63 has a 6-bit control field written through a small synchronous register port. The same port holds the 64-bit mask, which is stored as eight bytes.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset every control field reads 0x00, every mask byte reads 0xFF, `irq_level` is 0 and `vec_valid` is 0.
- R2: A write to address 8..63 stores `cfg_wdata[5:0]` as the control field of that source, with the level in bits [5:3] and the priority in bits [2:0]. A read returns `{2'b00, field}`. Writes to addresses 0..7 are ignored and those addresses read 0. Address 64+k holds mask bits [8k+7:8k]. `cfg_rdata` is registered, so it shows the addressed value from before any write in the same cycle, one cycle later.
- R3: A source is recognized only when its request is 1 and its mask bit is 0. A programmable source whose level field is 0 is never recognized.
- R4: One cycle after the inputs, `irq_level` equals the highest level among the recognized sources, or 0 when there are none.
- R5: Source n (1..7) is fixed at level n.
- R6: `iack_valid` in cycle t gives `vec_valid`=1 in cycle t+1, with `vec_num` = 64 + the number of the best recognized source at `iack_level`. A higher priority code wins. At all other times `vec_valid` is 0.
- R7: A fixed source beats programmable priorities 3..0 at its own level and loses to priorities 7..4.
- R8: When two programmable sources share both level and priority, the one with the lower number wins.
- R9: When no recognized source sits at the acknowledged level (this includes level 0), `vec_num` is the spurious vector 24.
- R10: When a write and an acknowledge fall in the same cycle, the vector is resolved from the control and mask contents as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 63 | Request lines for sources 63..1 |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 7 | Register address: 0..63 control, 64..71 mask bytes |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data of `cfg_addr` |
| iack_valid | input | 1 | Acknowledge strobe from the core |
| iack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Highest pending level to the core |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec_num | output | 8 | Vector number for the acknowledged level |

## Verification
A register write and an acknowledge can fall in the same cycle. The write may even target the control field or mask byte of the source that is about to win. The bench provokes this directly: it moves a winning source to another level in the acknowledge cycle and expects the old winner's vector, then expects the new winner on the next acknowledge. The random phase also issues writes and acknowledges together freely. A reference model predicts each result from the register image held before the write and applies the write only afterwards.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int LVL_W  = 3;
    localparam int PRI_W  = 3;
    localparam int CTRL_W = LVL_W + PRI_W;
    localparam int RANK_W = PRI_W + 1;
    localparam int HALF_PRI = 2 ** (PRI_W - 1);
    localparam logic [7:0] VEC_BASE = 8'd64;
    localparam logic [7:0] VEC_SPUR = 8'd24;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_ctl_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int NUM_FIXED = 7,
    parameter int ADDR_W    = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [7:0]                     wdata,
    output logic [7:0]                     rdata,
    output logic [NUM_SRC-1:0][CTRL_W-1:0] ctrl,
    output logic [NUM_SRC-1:0]             mask
);
    localparam int MASK_BYTES = NUM_SRC / 8;
    localparam int MASK_BASE  = NUM_SRC;
    localparam int IDX_W      = $clog2(NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0][CTRL_W-1:0] ctrl;
        logic [NUM_SRC-1:0]             mask;
        logic [7:0]                     rdata;
    } regs_t;

    regs_t state_d, state_q;
    int    a_int;
    logic  is_prog, is_mask;

    assign a_int   = int'(addr);
    assign is_prog = (a_int > NUM_FIXED) && (a_int < NUM_SRC);
    assign is_mask = (a_int >= MASK_BASE) && (a_int < MASK_BASE + MASK_BYTES);

    always_comb begin
        state_d = state_q;
        if (is_prog) begin
            state_d.rdata = 8'(state_q.ctrl[addr[IDX_W-1:0]]);
        end else if (is_mask) begin
            state_d.rdata = state_q.mask[(a_int - MASK_BASE) * 8 +: 8];
        end else begin
            state_d.rdata = 8'h00;
        end
        if (we && is_prog) begin
            state_d.ctrl[addr[IDX_W-1:0]] = wdata[CTRL_W-1:0];
        end
        if (we && is_mask) begin
            state_d.mask[(a_int - MASK_BASE) * 8 +: 8] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.ctrl  <= '0;
            state_q.mask  <= '1;
            state_q.rdata <= 8'h00;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata = state_q.rdata;
    assign ctrl  = state_q.ctrl;
    assign mask  = state_q.mask;

    AST_FIXED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (a_int <= NUM_FIXED) |=> (rdata == 8'h00)); // R2
endmodule

// File: rtl/irq_rank.sv
module irq_rank
    import irq_ctl_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int NUM_FIXED = 7
) (
    input  logic [NUM_SRC-1:1]             req,
    input  logic [NUM_SRC-1:0][CTRL_W-1:0] ctrl,
    input  logic [NUM_SRC-1:0]             mask,
    output logic [NUM_SRC-1:0]             recog,
    output logic [NUM_SRC-1:0][LVL_W-1:0]  lvl,
    output logic [NUM_SRC-1:0][RANK_W-1:0] rank
);
    assign recog[0] = 1'b0;
    assign lvl[0]   = '0;
    assign rank[0]  = '0;

    for (genvar s = 1; s < NUM_SRC; s++) begin : g_src
        if (s <= NUM_FIXED) begin : g_fixed
            assign lvl[s]   = LVL_W'(s);
            assign rank[s]  = RANK_W'(HALF_PRI);
            assign recog[s] = req[s] && !mask[s];
        end else begin : g_prog
            logic [PRI_W-1:0] pri;
            assign lvl[s]   = ctrl[s][CTRL_W-1:PRI_W];
            assign pri      = ctrl[s][PRI_W-1:0];
            assign rank[s]  = (int'(pri) < HALF_PRI) ? RANK_W'(pri)
                                                    : RANK_W'(pri) + RANK_W'(1);
            assign recog[s] = req[s] && !mask[s] && (lvl[s] != '0);
        end
    end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_ctl_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0]             recog,
    input  logic [NUM_SRC-1:0][LVL_W-1:0]  lvl,
    input  logic [NUM_SRC-1:0][RANK_W-1:0] rank,
    input  logic                           iack_valid,
    input  logic [LVL_W-1:0]               iack_level,
    output logic [LVL_W-1:0]               irq_level,
    output logic                           vec_valid,
    output logic [7:0]                     vec_num
);
    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             vld;
        logic [7:0]       vec;
    } arb_t;

    arb_t             arb_d, arb_q;
    logic [LVL_W-1:0] lmax;
    logic             found;
    logic [RANK_W-1:0] best;
    int               win;

    always_comb begin
        lmax  = '0;
        found = 1'b0;
        best  = '0;
        win   = 0;
        for (int s = NUM_SRC - 1; s >= 1; s--) begin
            if (recog[s] && (lvl[s] > lmax)) begin
                lmax = lvl[s];
            end
            if (recog[s] && (lvl[s] == iack_level) && (!found || rank[s] >= best)) begin
                found = 1'b1;
                best  = rank[s];
                win   = s;
            end
        end
        arb_d       = arb_q;
        arb_d.level = lmax;
        arb_d.vld   = iack_valid;
        if (iack_valid) begin
            arb_d.vec = found ? (VEC_BASE + 8'(win)) : VEC_SPUR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q <= '0;
        end else begin
            arb_q <= arb_d;
        end
    end

    assign irq_level = arb_q.level;
    assign vec_valid = arb_q.vld;
    assign vec_num   = arb_q.vec;

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (recog == '0) |=> (irq_level == '0)); // R4
    AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        iack_valid |=> vec_valid); // R6
    AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_valid |=> !vec_valid); // R6
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_num == VEC_SPUR || vec_num > VEC_BASE)); // R9
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
    import irq_ctl_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int NUM_FIXED = 7,
    parameter int ADDR_W    = $clog2(NUM_SRC + NUM_SRC / 8)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:1]   irq_req,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_rdata,
    input  logic                 iack_valid,
    input  logic [LVL_W-1:0]     iack_level,
    output logic [LVL_W-1:0]     irq_level,
    output logic                 vec_valid,
    output logic [7:0]           vec_num
);
    logic [NUM_SRC-1:0][CTRL_W-1:0] ctrl;
    logic [NUM_SRC-1:0]             mask;
    logic [NUM_SRC-1:0]             recog;
    logic [NUM_SRC-1:0][LVL_W-1:0]  lvl;
    logic [NUM_SRC-1:0][RANK_W-1:0] rank;

    irq_regs #(.NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .ctrl(ctrl), .mask(mask)
    );

    irq_rank #(.NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED)) u_rank (
        .req(irq_req), .ctrl(ctrl), .mask(mask),
        .recog(recog), .lvl(lvl), .rank(rank)
    );

    irq_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk(clk), .rst_n(rst_n), .recog(recog), .lvl(lvl), .rank(rank),
        .iack_valid(iack_valid), .iack_level(iack_level),
        .irq_level(irq_level), .vec_valid(vec_valid), .vec_num(vec_num)
    );

    AST_ACK_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_num != VEC_SPUR) |-> ($past(iack_level) != '0)); // R3
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & mask[NUM_SRC-1:1]) == irq_req) |=> (irq_level == '0)); // R3
endmodule

// File: tb/tb_irq_ctl_top.sv
`timescale 1ns/1ps
module tb_irq_ctl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:1] irq_req = '0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        iack_valid = 1'b0;
    logic [2:0]  iack_level = '0;
    logic [2:0]  irq_level;
    logic        vec_valid;
    logic [7:0]  vec_num;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [5:0]  ctrl_m [64];
    logic [63:0] mask_m;

    always #4 clk = ~clk;

    irq_ctl_top dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .iack_valid(iack_valid), .iack_level(iack_level),
        .irq_level(irq_level), .vec_valid(vec_valid), .vec_num(vec_num)
    );

    function automatic void chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endfunction

    function automatic int src_lvl(int s);
        return (s <= 7) ? s : int'(ctrl_m[s][5:3]);
    endfunction

    // score on a doubled scale: programmable 2*p, fixed 7 (between 6 and 8)
    function automatic int src_score(int s);
        return (s <= 7) ? 7 : 2 * int'(ctrl_m[s][2:0]);
    endfunction

    function automatic bit live(int s, logic [63:1] r);
        return r[s] && !mask_m[s] && src_lvl(s) != 0;
    endfunction

    function automatic int exp_level(logic [63:1] r);
        int m = 0;
        for (int s = 1; s < 64; s++)
            if (live(s, r) && src_lvl(s) > m) m = src_lvl(s);
        return m;
    endfunction

    function automatic int exp_vec(logic [63:1] r, int l);
        int w = -1;
        int b = -1;
        for (int s = 1; s < 64; s++)
            if (live(s, r) && src_lvl(s) == l && src_score(s) > b) begin
                b = src_score(s);
                w = s;
            end
        return (w < 0) ? 24 : 64 + w;
    endfunction

    function automatic int exp_read(int a);
        if (a >= 8 && a < 64) return int'(ctrl_m[a]);
        if (a >= 64 && a < 72) return int'(mask_m[(a - 64) * 8 +: 8]);
        return 0;
    endfunction

    // one cycle: drive at negedge, predict from pre-write model, check next negedge
    task automatic step(string tag, bit we, int a, int wd, logic [63:1] r,
                        bit ack, int al, bit chk_vec = 1, bit chk_rd = 1);
        int el, ev, er;
        cfg_we = we; cfg_addr = 7'(a); cfg_wdata = 8'(wd);
        irq_req = r; iack_valid = ack; iack_level = 3'(al);
        el = exp_level(r);
        ev = exp_vec(r, al);
        er = exp_read(a);
        if (we && a >= 8 && a < 64) ctrl_m[a] = 6'(wd);
        if (we && a >= 64 && a < 72) mask_m[(a - 64) * 8 +: 8] = 8'(wd);
        @(negedge clk);
        cfg_we = 1'b0; iack_valid = 1'b0;
        chk({tag, " level"}, int'(irq_level), el);
        chk({tag, " vld"}, int'(vec_valid), int'(ack));
        if (ack && chk_vec) chk({tag, " vec"}, int'(vec_num), ev);
        if (chk_rd) chk({tag, " rdata"}, int'(cfg_rdata), er);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:1] r;
        for (int i = 0; i < 64; i++) ctrl_m[i] = '0;
        mask_m = '1;
        void'($urandom(32'd7341));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset level", int'(irq_level), 0);
        chk("R1 reset vld", int'(vec_valid), 0);
        step("R1 ctrl", 0, 9, 0, '1, 0, 0);
        step("R1 mask", 0, 64, 0, '1, 1, 5);
        step("R1 mask7", 0, 71, 0, '0, 0, 0);

        // R2: register port
        step("R2 wr", 1, 10, 8'hFF, '0, 0, 0);
        step("R2 rd", 0, 10, 0, '0, 0, 0);
        step("R2 wrfixed", 1, 3, 8'h2B, '0, 0, 0);
        step("R2 rdfixed", 0, 3, 0, '0, 0, 0);
        step("R2 wrrd_same", 1, 12, 8'h15, '0, 0, 0);
        step("R2 rdnew", 0, 12, 0, '0, 0, 0);
        for (int k = 64; k < 72; k++) step("R2 unmask", 1, k, 0, '0, 0, 0);

        // R5: fixed source at its own level
        r = '0; r[5] = 1'b1;
        step("R5 fixed5", 0, 0, 0, r, 1, 5);
        r = '0; r[1] = 1'b1; r[7] = 1'b1;
        step("R5 fixed7", 0, 0, 0, r, 1, 7);
        step("R5 fixed1", 0, 0, 0, r, 1, 1);

        // R7: midpoint ranking
        step("R7 cfg10", 1, 10, {2'b0, 3'd5, 3'd4}, '0, 0, 0);
        step("R7 cfg11", 1, 11, {2'b0, 3'd5, 3'd3}, '0, 0, 0);
        r = '0; r[5] = 1'b1; r[10] = 1'b1; r[11] = 1'b1;
        step("R7 pri4beats", 0, 0, 0, r, 1, 5);
        r[10] = 1'b0;
        step("R7 beatspri3", 0, 0, 0, r, 1, 5);

        // R8: ties
        step("R8 cfg20", 1, 20, {2'b0, 3'd6, 3'd2}, '0, 0, 0);
        step("R8 cfg21", 1, 21, {2'b0, 3'd6, 3'd2}, '0, 0, 0);
        r = '0; r[20] = 1'b1; r[21] = 1'b1;
        step("R8 tie", 0, 0, 0, r, 1, 6);

        // R10: write and ack in the same cycle
        step("R10 same", 1, 20, {2'b0, 3'd1, 3'd2}, r, 1, 6);
        step("R10 after", 0, 0, 0, r, 1, 6);
        step("R10 mask_same", 1, 66, 8'h20, r, 1, 6);
        step("R10 mask_after", 0, 0, 0, r, 1, 6);
        step("R10 unmask", 1, 66, 8'h00, '0, 0, 0);

        // R9: spurious
        step("R9 empty", 0, 0, 0, r, 1, 3);
        step("R9 level0", 0, 0, 0, r, 1, 0);

        // R3: level-0 programmable and masked sources
        step("R3 cfg30", 1, 30, {2'b0, 3'd0, 3'd7}, '0, 0, 0);
        r = '0; r[30] = 1'b1;
        step("R3 lvl0", 0, 0, 0, r, 1, 0);
        step("R3 mask0", 1, 64, 8'h08, '0, 0, 0);
        r = '0; r[3] = 1'b1;
        step("R3 masked", 0, 0, 0, r, 1, 3);
        r[4] = 1'b1;
        step("R3 unmasked", 0, 0, 0, r, 1, 4);

        // R4/R6: random traffic
        for (int i = 0; i < 600; i++) begin
            bit we;
            int a, wd;
            we = ($urandom % 3) == 0;
            a  = (($urandom % 4) == 0) ? 64 + int'($urandom % 8) : int'($urandom % 72);
            wd = (a >= 64) ? int'($urandom & 32'h0000_0044) : int'($urandom % 256);
            r  = {$urandom, $urandom};
            r  = r & {$urandom, $urandom};
            step("R4 R6 random", we, a, wd, r, ($urandom % 2) == 1, int'($urandom % 8));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule